// File: doc/BRIEF.md
# Page Access Permission Check and Fault Recorder

This unit sits behind a page-table walker in a memory management unit. For every walk result it receives, it turns the leaf entry's 3-bit permission field, the kind of access (load, store or instruction fetch) and the privilege level into two things. The first is a fault code. The second is the set of read, write and execute rights that a translation cache may hold for that page. A nonzero fault code reported by the walker itself takes the place of the permission check.

On every fault the unit also updates two records that software reads. The status record holds the access index, the fault code, a valid bit and an overflow bit. The address record holds the page-aligned virtual address. A read strobe from software clears the status record. A fault either ends in a trap or, when no-fault mode is set or traps are disabled, finishes with full rights and no trap. The trap output tells an instruction fault apart from a data fault.

Top module: `perm_fault_unit`

## Requirements
- R1: The access index is (store<<2)|(fetch<<1)|supervisor. The store bit is `req_kind[0]` and the fetch bit is `req_kind[1]` (00 load, 01 store, 10 fetch, 11 store+fetch). From this index and the permission code, `rsp_code` is set as follows, checked in this order: 12 for a user access to permission 6 or 7; otherwise 8 when the page's rights for that privilege lack a right the access needs (load needs R, store needs W, fetch needs X, store+fetch needs W and X); otherwise 0.
- R2: When the access is a user access and `cfg_nofault` is set, a nonzero permission code from R1 is replaced by 0, and no fault is raised.
- R3: Granted rights are encoded with bit0 = R, bit1 = W and bit2 = X. For supervisor accesses, permission codes 0 to 7 give R, RW, RX, RWX, X, RW, RX and RWX. For user accesses they give R, RW, RX, RWX, X, R, none and none.
- R4: When `req_modified` is low, the W bit is removed from the granted rights of an access that does not fault.
- R5: A nonzero `req_walk_code` (level in bits 9:8, type in bits 4:2) is reported as the fault code in place of the permission check, and no-fault mode does not suppress it.
- R6: On a fault, the status record is first reduced to 1 (the overflow flag) if it held a nonzero value, or to 0 otherwise. The value (index<<5)|code|2 is then ORed into it.
- R7: On a fault, the address record captures `req_vaddr` with its low PAGE_BITS bits cleared.
- R8: A fault taken while `cfg_nofault` is high or `cfg_traps_en` is low completes with rights 7 and `rsp_trap` low.
- R9: Any other fault raises `rsp_trap` with rights 0. `rsp_trap_fetch` is high exactly when the fetch bit of the access kind is set.
- R10: `sts_read` returns the current status record on `fsr_data` in the same cycle and clears the record at the next clock edge.
- R11: When a fault and `sts_read` fall in the same cycle, the record takes the new fault's value without the overflow flag.
- R12: After reset, `rsp_valid`, `fsr_data` and `far_data` are 0. Every response output reflects the request one clock edge after `req_valid`, and `rsp_valid` is high only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A walk result is presented |
| req_vaddr | input | VA_W | Virtual address of the access |
| req_kind | input | 2 | Access kind: bit0 store, bit1 fetch |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| req_walk_code | input | 10 | Walker fault code, 0 when the walk succeeded |
| req_perm | input | 3 | Leaf permission field |
| req_modified | input | 1 | Leaf modified bit |
| cfg_nofault | input | 1 | No-fault mode |
| cfg_traps_en | input | 1 | Traps enabled |
| sts_read | input | 1 | Software read strobe for the status record |
| rsp_valid | output | 1 | Response valid |
| rsp_rights | output | 3 | Granted rights {X,W,R} |
| rsp_code | output | 10 | Fault code of the access |
| rsp_fault | output | 1 | The access faulted |
| rsp_trap | output | 1 | A trap is raised |
| rsp_trap_fetch | output | 1 | The trap is an instruction fault |
| fsr_data | output | 10 | Status record |
| far_data | output | VA_W | Fault address record |

## Verification
Every response output and both records change at the first rising edge after `req_valid`. The bench therefore drives a request on a falling edge and samples the results on the next falling edge. A status read is checked twice: the read data is sampled in the cycle the strobe is high, and the cleared value one edge later. A fault and a read landing in the same cycle are checked at that same next edge.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
   localparam int CODE_W  = 10;
   localparam int IDX_W   = 3;
   localparam int RIGHT_W = 3;

   localparam logic [RIGHT_W-1:0] RT_R   = 3'b001;
   localparam logic [RIGHT_W-1:0] RT_W   = 3'b010;
   localparam logic [RIGHT_W-1:0] RT_X   = 3'b100;
   localparam logic [RIGHT_W-1:0] RT_ALL = 3'b111;

   typedef enum logic [1:0] {
      KIND_LOAD  = 2'b00,
      KIND_STORE = 2'b01,
      KIND_FETCH = 2'b10,
      KIND_BOTH  = 2'b11
   } kind_e;

   function automatic logic [31:0] pack_codes(
      input logic [3:0] c0, input logic [3:0] c1, input logic [3:0] c2, input logic [3:0] c3,
      input logic [3:0] c4, input logic [3:0] c5, input logic [3:0] c6, input logic [3:0] c7);
      return {c7, c6, c5, c4, c3, c2, c1, c0};
   endfunction

   // Permission fault code by access index row and permission column.
   function automatic logic [3:0] lookup_code(input logic [IDX_W-1:0] idx, input logic [2:0] perm);
      logic [31:0] row;
      case (idx)
         3'd0:    row = pack_codes(0, 0, 0, 0, 8, 0, 12, 12);
         3'd1:    row = pack_codes(0, 0, 0, 0, 8, 0, 0, 0);
         3'd2:    row = pack_codes(8, 8, 0, 0, 0, 8, 12, 12);
         3'd3:    row = pack_codes(8, 8, 0, 0, 0, 8, 0, 0);
         3'd4:    row = pack_codes(8, 0, 8, 0, 8, 8, 12, 12);
         3'd5:    row = pack_codes(8, 0, 8, 0, 8, 0, 8, 0);
         3'd6:    row = pack_codes(8, 8, 8, 0, 8, 8, 12, 12);
         default: row = pack_codes(8, 8, 8, 0, 8, 8, 8, 0);
      endcase
      return row[perm*4 +: 4];
   endfunction

   function automatic logic [RIGHT_W-1:0] lookup_rights(input logic user, input logic [2:0] perm);
      logic [RIGHT_W-1:0] r;
      case (perm)
         3'd0:    r = RT_R;
         3'd1:    r = RT_R | RT_W;
         3'd2:    r = RT_R | RT_X;
         3'd3:    r = RT_ALL;
         3'd4:    r = RT_X;
         3'd5:    r = user ? RT_R : (RT_R | RT_W);
         3'd6:    r = user ? 3'b000 : (RT_R | RT_X);
         default: r = user ? 3'b000 : RT_ALL;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/pfu_perm_check.sv
module pfu_perm_check
   import pfu_pkg::*;
(
   input  logic [1:0]          kind,
   input  logic                user,
   input  logic [2:0]          perm,
   input  logic                modified,
   input  logic                nofault,
   input  logic [CODE_W-1:0]   walk_code,
   output logic [IDX_W-1:0]    acc_idx,
   output logic [CODE_W-1:0]   code,
   output logic [RIGHT_W-1:0]  rights
);
   logic [3:0]         tbl_code;
   logic               suppress;
   logic [RIGHT_W-1:0] granted;

   always_comb begin
      acc_idx  = {kind[0], kind[1], ~user};
      tbl_code = lookup_code(acc_idx, perm);
      suppress = user && nofault;
      granted  = lookup_rights(user, perm);
      if (walk_code != '0)
         code = walk_code;
      else if (suppress)
         code = '0;
      else
         code = CODE_W'(tbl_code);
      rights = modified ? granted : (granted & ~RT_W);
   end

   always_comb begin
      if (walk_code == '0 && suppress)
         assert_nofault_user_R2 : assert (code == '0);
   end
endmodule

// File: rtl/pfu_fault_status.sv
module pfu_fault_status
   import pfu_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flt_valid,
   input  logic [CODE_W-1:0] flt_entry,
   input  logic [VA_W-1:0]   flt_addr,
   input  logic              sts_read,
   output logic [CODE_W-1:0] fsr_q,
   output logic [VA_W-1:0]   far_q
);
   localparam logic [CODE_W-1:0] OV_FLAG = CODE_W'(1);

   logic [CODE_W-1:0] base;

   always_comb begin
      base = (fsr_q != '0 && !sts_read) ? OV_FLAG : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsr_q <= '0;
         far_q <= '0;
      end else if (flt_valid) begin
         fsr_q <= base | flt_entry;
         far_q <= {flt_addr[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
      end else if (sts_read) begin
         fsr_q <= '0;
      end
   end

   assert_valid_set_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid |=> fsr_q[1]);
   assert_overflow_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid && !sts_read && fsr_q != '0 |=> fsr_q[0]);
   assert_read_clear_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      sts_read && !flt_valid |=> fsr_q == '0);
   assert_fault_wins_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      sts_read && flt_valid |=> fsr_q[1] && !fsr_q[0]);
   assert_far_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !flt_valid |=> $stable(far_q));
endmodule

// File: rtl/pfu_resp_stage.sv
module pfu_resp_stage
   import pfu_pkg::*;
#(
   parameter bit REGISTERED = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [RIGHT_W-1:0] in_rights,
   input  logic [CODE_W-1:0]  in_code,
   input  logic               in_fault,
   input  logic               in_trap,
   input  logic               in_fetch,
   output logic               out_valid,
   output logic [RIGHT_W-1:0] out_rights,
   output logic [CODE_W-1:0]  out_code,
   output logic               out_fault,
   output logic               out_trap,
   output logic               out_fetch
);
   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid  <= 1'b0;
               out_rights <= '0;
               out_code   <= '0;
               out_fault  <= 1'b0;
               out_trap   <= 1'b0;
               out_fetch  <= 1'b0;
            end else begin
               out_valid  <= in_valid;
               out_rights <= in_valid ? in_rights : '0;
               out_code   <= in_valid ? in_code : '0;
               out_fault  <= in_valid && in_fault;
               out_trap   <= in_valid && in_trap;
               out_fetch  <= in_valid && in_trap && in_fetch;
            end
         end
         assert_rsp_latency_R12 : assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
      end else begin : g_comb
         always_comb begin
            out_valid  = in_valid;
            out_rights = in_valid ? in_rights : '0;
            out_code   = in_valid ? in_code : '0;
            out_fault  = in_valid && in_fault;
            out_trap   = in_valid && in_trap;
            out_fetch  = in_valid && in_trap && in_fetch;
         end
      end
   endgenerate
endmodule

// File: rtl/perm_fault_unit.sv
module perm_fault_unit
   import pfu_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter bit RSP_REG   = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic [1:0]         req_kind,
   input  logic               req_user,
   input  logic [9:0]         req_walk_code,
   input  logic [2:0]         req_perm,
   input  logic               req_modified,
   input  logic               cfg_nofault,
   input  logic               cfg_traps_en,
   input  logic               sts_read,
   output logic               rsp_valid,
   output logic [2:0]         rsp_rights,
   output logic [9:0]         rsp_code,
   output logic               rsp_fault,
   output logic               rsp_trap,
   output logic               rsp_trap_fetch,
   output logic [9:0]         fsr_data,
   output logic [VA_W-1:0]    far_data
);
   localparam int IDX_SHIFT = 5;

   generate
      if (VA_W <= PAGE_BITS) begin : g_bad_va
         $error("VA_W must exceed PAGE_BITS");
      end
      if (CODE_W < IDX_SHIFT + IDX_W) begin : g_bad_code
         $error("status record too narrow for access index");
      end
   endgenerate

   logic [IDX_W-1:0]   acc_idx;
   logic [CODE_W-1:0]  code;
   logic [RIGHT_W-1:0] page_rights;
   logic               fault;
   logic               excused;
   logic [RIGHT_W-1:0] final_rights;
   logic               trap;
   logic [CODE_W-1:0]  entry;

   pfu_perm_check u_check (
      .kind      (req_kind),
      .user      (req_user),
      .perm      (req_perm),
      .modified  (req_modified),
      .nofault   (cfg_nofault),
      .walk_code (req_walk_code),
      .acc_idx   (acc_idx),
      .code      (code),
      .rights    (page_rights)
   );

   always_comb begin
      fault   = req_valid && (code != '0);
      excused = cfg_nofault || !cfg_traps_en;
      trap    = fault && !excused;
      if (!fault)
         final_rights = page_rights;
      else if (excused)
         final_rights = RT_ALL;
      else
         final_rights = '0;
      entry = code | (CODE_W'(acc_idx) << IDX_SHIFT) | CODE_W'(2);
   end

   pfu_fault_status #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .flt_valid (fault),
      .flt_entry (entry),
      .flt_addr  (req_vaddr),
      .sts_read  (sts_read),
      .fsr_q     (fsr_data),
      .far_q     (far_data)
   );

   pfu_resp_stage #(.REGISTERED(RSP_REG)) u_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (req_valid),
      .in_rights  (final_rights),
      .in_code    (code),
      .in_fault   (fault),
      .in_trap    (trap),
      .in_fetch   (req_kind[1]),
      .out_valid  (rsp_valid),
      .out_rights (rsp_rights),
      .out_code   (rsp_code),
      .out_fault  (rsp_fault),
      .out_trap   (rsp_trap),
      .out_fetch  (rsp_trap_fetch)
   );

   assert_trap_no_rights_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_trap |-> rsp_rights == '0);
   assert_excused_full_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault && !rsp_trap |-> rsp_rights == RT_ALL);

   generate
      if (RSP_REG) begin : g_chk_reg
         assert_write_gated_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid && !rsp_fault && !$past(req_modified) |-> !rsp_rights[1]);
         assert_walk_priority_R5 : assert property (@(posedge clk) disable iff (!rst_n)
            req_valid && req_walk_code != '0 |=> rsp_code == $past(req_walk_code));
      end
   endgenerate
endmodule

// File: tb/perm_fault_unit_test.sv
`timescale 1ns/1ps
module perm_fault_unit_test;
   localparam int VA_W = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [VA_W-1:0] req_vaddr = '0;
   logic [1:0]      req_kind = '0;
   logic            req_user = 1'b0;
   logic [9:0]      req_walk_code = '0;
   logic [2:0]      req_perm = '0;
   logic            req_modified = 1'b1;
   logic            cfg_nofault = 1'b0;
   logic            cfg_traps_en = 1'b1;
   logic            sts_read = 1'b0;
   logic            rsp_valid;
   logic [2:0]      rsp_rights;
   logic [9:0]      rsp_code;
   logic            rsp_fault;
   logic            rsp_trap;
   logic            rsp_trap_fetch;
   logic [9:0]      fsr_data;
   logic [VA_W-1:0] far_data;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   perm_fault_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_kind(req_kind), .req_user(req_user), .req_walk_code(req_walk_code),
      .req_perm(req_perm), .req_modified(req_modified), .cfg_nofault(cfg_nofault),
      .cfg_traps_en(cfg_traps_en), .sts_read(sts_read), .rsp_valid(rsp_valid),
      .rsp_rights(rsp_rights), .rsp_code(rsp_code), .rsp_fault(rsp_fault),
      .rsp_trap(rsp_trap), .rsp_trap_fetch(rsp_trap_fetch), .fsr_data(fsr_data),
      .far_data(far_data)
   );

   // Stimulus {kind[1:0], user, perm[2:0]} and expected permission code[3:0].
   localparam logic [9:0] VEC [12] = '{
      {2'b00, 1'b1, 3'd0, 4'd0},
      {2'b00, 1'b1, 3'd4, 4'd8},
      {2'b00, 1'b1, 3'd6, 4'd12},
      {2'b00, 1'b0, 3'd6, 4'd0},
      {2'b01, 1'b1, 3'd5, 4'd8},
      {2'b01, 1'b0, 3'd5, 4'd0},
      {2'b01, 1'b0, 3'd6, 4'd8},
      {2'b10, 1'b1, 3'd4, 4'd0},
      {2'b10, 1'b0, 3'd5, 4'd8},
      {2'b10, 1'b1, 3'd7, 4'd12},
      {2'b01, 1'b1, 3'd3, 4'd0},
      {2'b10, 1'b0, 3'd0, 4'd8}
   };

   function automatic logic [2:0] model_rights(input logic user, input logic [2:0] p);
      logic [2:0] s [8] = '{3'd1, 3'd3, 3'd5, 3'd7, 3'd4, 3'd3, 3'd5, 3'd7};
      logic [2:0] u [8] = '{3'd1, 3'd3, 3'd5, 3'd7, 3'd4, 3'd1, 3'd0, 3'd0};
      return user ? u[p] : s[p];
   endfunction

   function automatic logic [3:0] model_code(input logic [1:0] k, input logic user, input logic [2:0] p);
      logic [2:0] need;
      need = k[0] ? (k[1] ? 3'd6 : 3'd2) : (k[1] ? 3'd4 : 3'd1);
      if (user && p >= 3'd6) return 4'd12;
      if ((model_rights(user, p) & need) != need) return 4'd8;
      return 4'd0;
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Drive one request on a falling edge; results are sampled one edge later.
   task automatic issue(input logic [1:0] k, input logic u, input logic [2:0] p,
                        input logic m, input logic [9:0] w, input logic [VA_W-1:0] va,
                        input logic rd);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_user = u; req_perm = p;
      req_modified = m; req_walk_code = w; req_vaddr = va; sts_read = rd;
      @(negedge clk);
      req_valid = 1'b0; sts_read = 1'b0; req_walk_code = '0;
   endtask

   task automatic clear_fsr();
      sts_read = 1'b1;
      @(negedge clk);
      sts_read = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R12", "reset rsp_valid", rsp_valid, 0);
      chk("R12", "reset fsr", fsr_data, 0);
      chk("R12", "reset far", far_data, 0);
      rst_n = 1'b1;

      // Vector table: permission code, rights and trap direction (R1, R3, R9).
      foreach (VEC[i]) begin
         logic [1:0] k;
         logic u;
         logic [2:0] p;
         logic [3:0] ec;
         k = VEC[i][9:8]; u = VEC[i][7]; p = VEC[i][6:4]; ec = VEC[i][3:0];
         issue(k, u, p, 1'b1, '0, 32'h1000_0000 + 32'(i), 1'b0);
         chk("R12", "rsp_valid", rsp_valid, 1);
         chk("R1", "table code", rsp_code, 32'(ec));
         chk("R3", "rights", rsp_rights, ec == 0 ? 32'(model_rights(u, p)) : 0);
         chk("R9", "trap", rsp_trap, ec != 0);
         chk("R9", "trap_fetch", rsp_trap_fetch, ec != 0 && k[1]);
         clear_fsr();
      end

      // Exhaustive sweep of kinds, privilege and permission (R1, R3).
      for (int k = 0; k < 4; k++) begin
         for (int u = 0; u < 2; u++) begin
            for (int p = 0; p < 8; p++) begin
               logic [3:0] ec;
               ec = model_code(2'(k), u[0], 3'(p));
               issue(2'(k), u[0], 3'(p), 1'b1, '0, '0, 1'b0);
               chk("R1", "sweep code", rsp_code, 32'(ec));
               chk("R3", "sweep rights", rsp_rights, ec == 0 ? 32'(model_rights(u[0], 3'(p))) : 0);
               clear_fsr();
            end
         end
      end
      @(negedge clk);
      chk("R12", "valid drops when idle", rsp_valid, 0);

      // R4: write right withheld when not modified.
      issue(2'b00, 1'b0, 3'd1, 1'b0, '0, '0, 1'b0);
      chk("R4", "rights unmodified", rsp_rights, 1);
      issue(2'b00, 1'b0, 3'd7, 1'b0, '0, '0, 1'b0);
      chk("R4", "rights unmodified rwx", rsp_rights, 5);

      // R5, R6, R7: walker fault on supervisor load, idx 1.
      issue(2'b00, 1'b0, 3'd3, 1'b1, 10'h104, 32'hABCD_E123, 1'b0);
      chk("R5", "walk code", rsp_code, 10'h104);
      chk("R6", "fsr first fault", fsr_data, 10'h126);
      chk("R7", "far aligned", far_data, 32'hABCD_E000);
      chk("R9", "data trap", {rsp_trap, rsp_trap_fetch}, 2'b10);

      // R6 overflow: user fetch perm 6 while record nonzero.
      issue(2'b10, 1'b1, 3'd6, 1'b1, '0, 32'h0000_5FFF, 1'b0);
      chk("R6", "fsr overflow", fsr_data, 10'h04F);
      chk("R9", "fetch trap", {rsp_trap, rsp_trap_fetch}, 2'b11);
      chk("R7", "far second", far_data, 32'h0000_5000);

      // R11: store user perm 0 faults in the same cycle as a read.
      issue(2'b01, 1'b1, 3'd0, 1'b1, '0, 32'h0000_7000, 1'b1);
      chk("R11", "fault wins over read", fsr_data, 10'h08A);

      // R10: read returns value then clears.
      @(negedge clk);
      sts_read = 1'b1;
      #1;
      chk("R10", "read data", fsr_data, 10'h08A);
      @(negedge clk);
      sts_read = 1'b0;
      chk("R10", "cleared", fsr_data, 0);

      // R2: user no-fault mode suppresses permission fault.
      cfg_nofault = 1'b1;
      issue(2'b00, 1'b1, 3'd6, 1'b1, '0, '0, 1'b0);
      chk("R2", "suppressed code", rsp_code, 0);
      chk("R2", "no fault", rsp_fault, 0);
      chk("R2", "fsr untouched", fsr_data, 0);
      // R5/R8: walk fault still taken, completes with full rights.
      issue(2'b10, 1'b1, 3'd0, 1'b1, 10'h204, 32'h0001_2345, 1'b0);
      chk("R5", "walk not suppressed", rsp_fault, 1);
      chk("R8", "nofault rights", rsp_rights, 7);
      chk("R8", "nofault no trap", rsp_trap, 0);
      cfg_nofault = 1'b0;
      clear_fsr();

      // R8: traps disabled.
      cfg_traps_en = 1'b0;
      issue(2'b01, 1'b0, 3'd0, 1'b1, '0, '0, 1'b0);
      chk("R8", "traps off code", rsp_code, 8);
      chk("R8", "traps off rights", rsp_rights, 7);
      chk("R8", "traps off no trap", rsp_trap, 0);
      chk("R6", "traps off fsr", fsr_data, 10'h0AA);
      cfg_traps_en = 1'b1;

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule